// File: doc/BRIEF.md
# Wired and Message Interrupt Merger

This block gathers 64 interrupt sources into one upstream interrupt request. The lower 21 sources come straight from level-sensitive wires. The upper 43 sources are message-signalled: a peripheral, or any bus master, raises one by writing that source's number to a single doorbell address. Every source owns one pending cause bit and one mask bit. The cause bits are packed 32 to a word, and the mask bits are laid out the same way.

Software acknowledges a pending source by writing 1 to its cause bit. It enables a source by clearing that source's mask bit, because a mask bit of 1 blocks the source. The upstream request is registered. It is high whenever at least one cause bit is set while its mask bit is clear.

The register bus is a plain single-cycle port with no back-pressure: a write takes effect at the clock edge where `bus_wr` is sampled high. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled high. The register offsets are fixed: cause words at 0x00 and 0x04, mask words at 0x20 and 0x24, and the doorbell at 0x30.

Top module: `irq_merge_top`

## Requirements
- R1: After reset every cause bit reads 0, both mask words read 0xFFFFFFFF, and `irq_out` is 0.
- R2: Source n sits in cause word n/32 at bit n%32. Cause word 0 is at offset 0x00 and word 1 at offset 0x04. A read returns the word in `bus_rdata` one cycle after `bus_rd`.
- R3: Sources 0 to 20 follow `wired_irq[n]`. While the input is high, the cause bit is set again on every clock, so an acknowledge issued during that time leaves the bit set. Once the input is low, the bit stays set until it is acknowledged.
- R4: A write to offset 0x30 with data n, where n is between 21 and 63, sets cause bit n. A set arriving in the same cycle as an acknowledge of the same bit wins.
- R5: A doorbell write whose data is below 21 or above 63 changes no cause bit.
- R6: Writing a cause word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: The mask words sit at offsets 0x20 (sources 0 to 31) and 0x24 (sources 32 to 63). A write replaces the word, and the word reads back as written. A mask bit of 1 keeps its source out of `irq_out` but does not clear the cause bit.
- R8: `irq_out` rises in the cycle after an unmasked cause bit becomes set. It falls in the cycle after the last unmasked set cause bit clears.
- R9: A read of any other offset, including 0x30, returns 0. A write to any other offset changes no cause or mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wired_irq | input | 21 | Level-sensitive source inputs, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq_out | output | 1 | Upstream interrupt request, registered |

## Verification
The per-bit assertions take for granted that the bus makes at most one access per cycle. Under that condition, a cause bit can be touched in a single cycle only by its own set source and by an acknowledge of its own word. The stimulus drives one bus access at a time, always on the falling edge, and changes the wired inputs only between accesses. The only same-cycle set-and-acknowledge case the bench builds is a wired input held high across an acknowledge.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int CAUSE_BASE  = 'h00;
  localparam int MASK_BASE   = 'h20;
  localparam int DOORBELL    = 'h30;
  localparam int WORD_STRIDE = 4;
endpackage

// File: rtl/irqm_busdec.sv
module irqm_busdec import irqm_pkg::*; #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int NUM_WORDS = NUM_SRC / DATA_W,
  localparam int NUM_DB    = NUM_SRC - NUM_WIRED
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SRC-1:0]   ack,
  output logic [NUM_DB-1:0]    db_set,
  output logic [NUM_WORDS-1:0] mask_we
);
  logic db_hit;
  assign db_hit = wr_en && (addr == ADDR_W'(DOORBELL));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic cause_hit;
    assign cause_hit = wr_en && (addr == ADDR_W'(CAUSE_BASE + w * WORD_STRIDE));
    assign ack[w*DATA_W +: DATA_W] = cause_hit ? wdata : '0;
    assign mask_we[w] = wr_en && (addr == ADDR_W'(MASK_BASE + w * WORD_STRIDE));
  end

  // full-width compare: any number outside the doorbell range matches nothing
  for (genvar d = 0; d < NUM_DB; d++) begin : g_db
    assign db_set[d] = db_hit && (wdata == DATA_W'(d + NUM_WIRED));
  end
endmodule

// File: rtl/irqm_cause.sv
module irqm_cause #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  localparam int NUM_DB   = NUM_SRC - NUM_WIRED
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired,
  input  logic [NUM_DB-1:0]    db_set,
  input  logic [NUM_SRC-1:0]   ack,
  output logic [NUM_SRC-1:0]   cause_q
);
  logic [NUM_SRC-1:0] set_w;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_WIRED) begin : g_wired
      assign set_w[i] = wired[i];
    end else begin : g_msg
      assign set_w[i] = db_set[i-NUM_WIRED];
    end

    // R6: an acknowledge with no set present clears the bit
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_w[i]) |=> !cause_q[i]);
    // R3 / R4: a set always lands, even against an acknowledge
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_w[i] |=> cause_q[i]);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack[i] && !set_w[i]) |=> $stable(cause_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~ack) | set_w;
  end
endmodule

// File: rtl/irqm_mask.sv
module irqm_mask #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS-1:0]        we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_WORDS*DATA_W-1:0] mask_q
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)     mask_q[w*DATA_W +: DATA_W] <= '1;
      else if (we[w]) mask_q[w*DATA_W +: DATA_W] <= wdata;
    end
  end

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top import irqm_pkg::*; #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_WIRED = 21,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired_irq,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_out
);
  localparam int NUM_WORDS = NUM_SRC / DATA_W;
  localparam int NUM_DB    = NUM_SRC - NUM_WIRED;

  logic [NUM_SRC-1:0]   ack;
  logic [NUM_DB-1:0]    db_set;
  logic [NUM_WORDS-1:0] mask_we;
  logic [NUM_SRC-1:0]   cause_q;
  logic [NUM_SRC-1:0]   mask_q;
  logic [DATA_W-1:0]    rd_mux;
  logic                 addr_hit;

  irqm_busdec #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .DATA_W(DATA_W),
                .ADDR_W(ADDR_W)) u_dec (
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ack(ack), .db_set(db_set), .mask_we(mask_we));

  irqm_cause #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED)) u_cause (
    .clk(clk), .rst_n(rst_n), .wired(wired_irq), .db_set(db_set),
    .ack(ack), .cause_q(cause_q));

  irqm_mask #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(bus_wdata),
    .mask_q(mask_q));

  always_comb begin
    rd_mux   = '0;
    addr_hit = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(CAUSE_BASE + w * WORD_STRIDE)) begin
        rd_mux   = cause_q[w*DATA_W +: DATA_W];
        addr_hit = 1'b1;
      end
      if (bus_addr == ADDR_W'(MASK_BASE + w * WORD_STRIDE)) begin
        rd_mux   = mask_q[w*DATA_W +: DATA_W];
        addr_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      irq_out   <= |(cause_q & ~mask_q);
    end
  end

  p_db_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(db_set));
  p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_hit) |=> (bus_rdata == '0));
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|cause_q));
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == '0) |=> !irq_out);
endmodule

// File: tb/test_irq_merge_top.sv
module test_irq_merge_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] wired_irq = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_merge_top i_irq_merge_top (
    .clk(clk), .rst_n(rst_n), .wired_irq(wired_irq), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check_rd("R1 cause0", 8'h00, 32'h0);
    check_rd("R1 cause1", 8'h04, 32'h0);
    check_rd("R1 mask0", 8'h20, 32'hFFFF_FFFF);
    check_rd("R1 mask1", 8'h24, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_init;
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
    check_rd("R6 init cause0", 8'h00, 32'h0);
    check_rd("R7 init mask1", 8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic t_doorbell;
    wr(8'h20, 32'h0); wr(8'h24, 32'h0);
    check_rd("R7 mask0 readback", 8'h20, 32'h0);
    wr(8'h30, 32'd21);
    check("R8 irq not yet", {31'b0, irq_out}, 32'h0);
    @(posedge clk); #1;
    check("R8 irq rises", {31'b0, irq_out}, 32'h1);
    check_rd("R4 R2 src21", 8'h00, 32'h0020_0000);
    wr(8'h30, 32'd63);
    check_rd("R4 R2 src63", 8'h04, 32'h8000_0000);
    wr(8'h30, 32'd40);
    wr(8'h04, 32'h8000_0000);
    check_rd("R6 partial ack", 8'h04, 32'h0000_0100);
    wr(8'h00, 32'h0020_0000);
    check_rd("R6 ack word0", 8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R8 irq still high", {31'b0, irq_out}, 32'h1);
    @(posedge clk); #1;
    check("R8 irq falls", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_db_range;
    wr(8'h30, 32'd5); wr(8'h30, 32'd20); wr(8'h30, 32'd0);
    wr(8'h30, 32'd64); wr(8'h30, 32'h0001_0015);
    check_rd("R5 cause0 untouched", 8'h00, 32'h0);
    check_rd("R5 cause1 untouched", 8'h04, 32'h0);
    check("R5 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_mask;
    wr(8'h20, 32'h0040_0000);
    wr(8'h30, 32'd22);
    @(posedge clk); #1;
    check("R7 masked irq", {31'b0, irq_out}, 32'h0);
    check_rd("R7 cause kept", 8'h00, 32'h0040_0000);
    wr(8'h20, 32'h0);
    @(posedge clk); #1;
    check("R7 unmask irq", {31'b0, irq_out}, 32'h1);
    wr(8'h00, 32'h0040_0000);
    @(posedge clk); #1;
    check("R8 irq after ack", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_wired;
    @(negedge clk); wired_irq[3] = 1'b1; wired_irq[20] = 1'b1;
    check_rd("R3 R2 wired set", 8'h00, 32'h0010_0008);
    wr(8'h00, 32'h0000_0008);
    check_rd("R3 ack while high", 8'h00, 32'h0010_0008);
    @(negedge clk); wired_irq = '0;
    check_rd("R3 latched after drop", 8'h00, 32'h0010_0008);
    wr(8'h00, 32'h0010_0008);
    check_rd("R3 ack after drop", 8'h00, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(8'h20, 32'h1234_5678);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    check_rd("R9 read 0x10", 8'h10, 32'h0);
    check_rd("R9 read 0x28", 8'h28, 32'h0);
    check_rd("R9 read doorbell", 8'h30, 32'h0);
    check_rd("R9 mask0 untouched", 8'h20, 32'h1234_5678);
    check_rd("R9 mask1 untouched", 8'h24, 32'h0);
    check_rd("R9 cause0 untouched", 8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_init();
    t_doorbell();
    t_db_range();
    t_mask();
    t_wired();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule